// File: doc/BRIEF.md
# ADC Offset Compensation Calibrator

This block measures and removes the fixed offset error of a 10-bit converter. A start pulse puts it into compensation sensing, which is a state where the front end forces the converter input to mid-scale. The block then waits for the front end to settle. After that it takes sixteen fresh channel-0 results, one for each sample strobe. It averages them and stores a signed compensation value: mid-scale (512) minus the average. At the end it drops the sensing request, which restores normal conversion, and pulses a done flag.

When a calibration starts, the block also latches a 4-bit trim code from the fuse trim field. The code falls back to 8 when the fuse word cannot be read or the field is zero. The block scales results from the battery-sensing channel by 3 or by 3/2, depending on the divider-select bit. It applies the same gain to the compensation value, which gives a battery-channel offset. Control of the analog front end itself stays outside the block.

Top module: `adc_offset_cal`

## Requirements
- R1: After reset, cv_o is 0, trim_o is 8, bat_result_o is 0, and done_o and comp_sense_o are low.
- R2: A start_i pulse seen while idle raises comp_sense_o on the next clock. comp_sense_o stays high until the clock on which done_o rises, and it falls on that same clock.
- R3: Sample strobes during the settling window are ignored. The window is the SETTLE_CYCLES clocks after the start is registered.
- R4: After settling, exactly 16 strobes with bat_chan_i low are accumulated. Strobes with bat_chan_i high are not accumulated.
- R5: cv_o is the 11-bit two's complement value 512 - (sum of the 16 results >> 4). It is updated together with the done pulse and held until the next update.
- R6: A start_i pulse during a calibration has no effect. The calibration neither restarts nor reloads the trim code.
- R7: At each registered start, trim_o loads fuse_trim_i when fuse_ok_i is 1 and the field is nonzero. Otherwise it loads 8. trim_o is never zero.
- R8: done_o is high for exactly one clock per completed calibration.
- R9: One clock after a strobe with bat_chan_i high, bat_result_o equals result_i*3 when div_sel_i is 1, or result_i*3/2 truncated when div_sel_i is 0. This holds whether or not a calibration is running.
- R10: bat_offset_o (12-bit signed) equals cv_o*3 when div_sel_i is 1, or cv_o*3/2 truncated toward zero when div_sel_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a calibration |
| strobe_i | input | 1 | A new conversion result is present |
| bat_chan_i | input | 1 | The present result belongs to the battery channel |
| result_i | input | 10 | Conversion result |
| fuse_trim_i | input | 4 | Trim field from the fuse word |
| fuse_ok_i | input | 1 | The fuse word was read successfully |
| div_sel_i | input | 1 | Battery divider select: 1 gives gain 3, 0 gives gain 3/2 |
| comp_sense_o | output | 1 | Request to force the input to mid-scale |
| done_o | output | 1 | One-clock pulse when cv_o updates |
| cv_o | output | 11 | Signed compensation value |
| trim_o | output | 4 | Compensation trim code |
| bat_result_o | output | 12 | Scaled battery-channel result |
| bat_offset_o | output | 12 | Signed battery-channel offset |

## Verification
The hardest cases to reach are those where a strobe arrives but must not count. These are strobes inside the settling window, battery-channel strobes interleaved with the calibration samples, and a second start pulse in the middle of sampling. Each randomized calibration sends junk full-scale strobes during settling and inserts a battery strobe part way through the 16 samples. Some calibrations also pulse start again with a different fuse field. Any of these strobes or pulses, if wrongly taken, shifts the compensation value or the trim code away from the bench's computed result. Directed runs cover all-zero, all-mid-scale and all-full-scale inputs, where the value reaches 512, 0 and -511.

// File: rtl/adc_offset_cal.sv
module adc_offset_cal #(
  parameter int RES_W         = 10,
  parameter int SAMP_LOG2     = 4,
  parameter int TRIM_W        = 4,
  parameter int TRIM_DEFAULT  = 8,
  parameter int SETTLE_CYCLES = 250000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    strobe_i,
  input  logic                    bat_chan_i,
  input  logic [RES_W-1:0]        result_i,
  input  logic [TRIM_W-1:0]       fuse_trim_i,
  input  logic                    fuse_ok_i,
  input  logic                    div_sel_i,
  output logic                    comp_sense_o,
  output logic                    done_o,
  output logic signed [RES_W:0]   cv_o,
  output logic [TRIM_W-1:0]       trim_o,
  output logic [RES_W+1:0]        bat_result_o,
  output logic signed [RES_W+1:0] bat_offset_o
);
  localparam int NSAMP = 1 << SAMP_LOG2;
  localparam int SUM_W = RES_W + SAMP_LOG2;
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [RES_W:0] MID = (RES_W+1)'(1) << (RES_W - 1);
  localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYCLES - 1);
  localparam logic [SAMP_LOG2-1:0] N_LAST = SAMP_LOG2'(NSAMP - 1);

  typedef enum logic [1:0] {IDLE, SETTLE, SAMPLE} state_t;

  state_t               state;
  logic [SET_W-1:0]     set_cnt;
  logic [SAMP_LOG2-1:0] n_cnt;
  logic [SUM_W-1:0]     sum;
  logic [SUM_W-1:0]     sum_nxt;
  logic [RES_W-1:0]     avg;
  logic                 cal_take;
  logic [RES_W+1:0]     res3;
  logic [RES_W+2:0]     off3;
  logic [RES_W+2:0]     off_half;

  assign sum_nxt  = sum + SUM_W'(result_i);
  assign avg      = sum_nxt[SUM_W-1:SAMP_LOG2];
  assign cal_take = (state == SAMPLE) && strobe_i && !bat_chan_i;
  assign comp_sense_o = (state != IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      set_cnt <= '0;
      n_cnt   <= '0;
      sum     <= '0;
      cv_o    <= '0;
      done_o  <= 1'b0;
      trim_o  <= TRIM_W'(TRIM_DEFAULT);
    end else begin
      done_o <= 1'b0;
      case (state)
        IDLE: if (start_i) begin
          state   <= SETTLE;
          set_cnt <= '0;
          n_cnt   <= '0;
          sum     <= '0;
          trim_o  <= (fuse_ok_i && fuse_trim_i != '0) ? fuse_trim_i
                                                     : TRIM_W'(TRIM_DEFAULT);
        end
        SETTLE: begin
          if (set_cnt == SET_LAST) state <= SAMPLE;
          else set_cnt <= set_cnt + 1'b1;
        end
        SAMPLE: if (cal_take) begin
          sum   <= sum_nxt;
          n_cnt <= n_cnt + 1'b1;
          if (n_cnt == N_LAST) begin
            cv_o   <= $signed(MID - {1'b0, avg});
            done_o <= 1'b1;
            state  <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  assign res3 = (RES_W+2)'(result_i) + {1'b0, result_i, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) bat_result_o <= '0;
    else if (strobe_i && bat_chan_i)
      bat_result_o <= div_sel_i ? res3 : (res3 >> 1);
  end

  assign off3     = {{2{cv_o[RES_W]}}, cv_o} + {cv_o[RES_W], cv_o, 1'b0};
  assign off_half = $unsigned($signed(off3 + (RES_W+3)'(off3[RES_W+2])) >>> 1);
  assign bat_offset_o = div_sel_i ? $signed(off3[RES_W+1:0])
                                  : $signed(off_half[RES_W+1:0]);
endmodule

// File: rtl/adc_offset_cal_chk.sv
module adc_offset_cal_chk #(
  parameter int RES_W  = 10,
  parameter int TRIM_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start_i,
  input logic                  comp_sense_o,
  input logic                  done_o,
  input logic signed [RES_W:0] cv_o,
  input logic [TRIM_W-1:0]     trim_o
);
  p_start_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !comp_sense_o) |=> comp_sense_o);

  p_sense_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!comp_sense_o && $past(comp_sense_o)));

  p_cv_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(cv_o));

  p_trim_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trim_o != '0);

  p_trim_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(comp_sense_o) |-> $stable(trim_o));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

bind adc_offset_cal adc_offset_cal_chk #(.RES_W(RES_W), .TRIM_W(TRIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .comp_sense_o(comp_sense_o),
  .done_o(done_o), .cv_o(cv_o), .trim_o(trim_o)
);

// File: tb/adc_offset_cal_tb_top.sv
module adc_offset_cal_tb_top;
  localparam int SETTLE = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, strobe_i = 1'b0, bat_chan_i = 1'b0;
  logic [9:0] result_i = '0;
  logic [3:0] fuse_trim_i = '0;
  logic fuse_ok_i = 1'b0, div_sel_i = 1'b0;
  logic comp_sense_o, done_o;
  logic signed [10:0] cv_o;
  logic [3:0] trim_o;
  logic [11:0] bat_result_o;
  logic signed [11:0] bat_offset_o;

  int n_chk = 0, n_fail = 0;
  int samp[16];
  int cur_cv = 0;
  int cur_trim = 8;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_offset_cal #(.SETTLE_CYCLES(SETTLE)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .strobe_i(strobe_i),
    .bat_chan_i(bat_chan_i), .result_i(result_i), .fuse_trim_i(fuse_trim_i),
    .fuse_ok_i(fuse_ok_i), .div_sel_i(div_sel_i), .comp_sense_o(comp_sense_o),
    .done_o(done_o), .cv_o(cv_o), .trim_o(trim_o), .bat_result_o(bat_result_o),
    .bat_offset_o(bat_offset_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_cv();
    int s = 0;
    for (int i = 0; i < 16; i++) s += samp[i];
    return 512 - (s >> 4);
  endfunction

  function automatic int exp_trim(input int f, input bit ok);
    return (ok && f != 0) ? f : 8;
  endfunction

  function automatic int exp_bat(input int r, input bit d);
    return d ? r * 3 : (r * 3) / 2;
  endfunction

  task automatic bat_strobe(input int r, input bit d);
    @(negedge clk);
    strobe_i = 1; bat_chan_i = 1; result_i = 10'(r); div_sel_i = d;
    @(negedge clk);
    strobe_i = 0; bat_chan_i = 0;
    chk(int'(bat_result_o) == exp_bat(r, d), "R9 bat_result", int'(bat_result_o), exp_bat(r, d));
  endtask

  task automatic run_cal(input int fuse, input bit ok, input bit mid_start);
    @(negedge clk);
    fuse_trim_i = 4'(fuse); fuse_ok_i = ok; start_i = 1;
    @(negedge clk);
    start_i = 0;
    cur_trim = exp_trim(fuse, ok);
    chk(comp_sense_o == 1'b1, "R2 sense rises", int'(comp_sense_o), 1);
    chk(int'(trim_o) == cur_trim, "R7 trim load", int'(trim_o), cur_trim);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); strobe_i = 1; result_i = 10'd1023;
      @(negedge clk); strobe_i = 0;
    end
    repeat (SETTLE - 14) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      if (i == 5) bat_strobe(int'($urandom_range(0, 1023)), 1'($urandom_range(0, 1)));
      if (i == 8 && mid_start) begin
        @(negedge clk);
        start_i = 1; fuse_trim_i = 4'(cur_trim ^ 4'h5); fuse_ok_i = 1;
        @(negedge clk);
        start_i = 0;
        chk(int'(trim_o) == cur_trim, "R6 trim kept on restart", int'(trim_o), cur_trim);
      end
      @(negedge clk);
      strobe_i = 1; bat_chan_i = 0; result_i = 10'(samp[i]);
      if (i == 15) begin
        chk(done_o == 1'b0, "R8 no early done", int'(done_o), 0);
        chk(int'(cv_o) == cur_cv, "R5 cv held", int'(cv_o), cur_cv);
      end
      @(negedge clk);
      strobe_i = 0;
      if (i == 15) begin
        cur_cv = exp_cv();
        chk(done_o == 1'b1, "R8 done pulse", int'(done_o), 1);
        chk(int'(cv_o) == cur_cv, "R5 R4 R3 cv value", int'(cv_o), cur_cv);
        chk(comp_sense_o == 1'b0, "R2 sense falls", int'(comp_sense_o), 0);
      end
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one clock", int'(done_o), 0);
    for (int d = 0; d < 2; d++) begin
      div_sel_i = 1'(d);
      #1;
      chk(int'(bat_offset_o) == exp_bat(cur_cv, 1'(d)), "R10 bat_offset",
          int'(bat_offset_o), exp_bat(cur_cv, 1'(d)));
    end
  endtask

  initial begin
    int unsigned cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cv_o == 0, "R1 cv reset", int'(cv_o), 0);
    chk(trim_o == 4'd8, "R1 trim reset", int'(trim_o), 8);
    chk(done_o == 0 && comp_sense_o == 0, "R1 flags reset", int'({done_o, comp_sense_o}), 0);
    chk(bat_result_o == 0, "R1 bat reset", int'(bat_result_o), 0);

    for (int i = 0; i < 16; i++) samp[i] = 512;
    run_cal(3, 1, 0);
    for (int i = 0; i < 16; i++) samp[i] = 0;
    run_cal(0, 1, 0);
    for (int i = 0; i < 16; i++) samp[i] = 1023;
    run_cal(9, 0, 1);
    for (int i = 0; i < 16; i++) samp[i] = (i == 0) ? 15 : 0;
    run_cal(15, 1, 0);
    for (int t = 0; t < 8; t++) begin
      for (int i = 0; i < 16; i++) samp[i] = int'($urandom_range(440, 600));
      run_cal(int'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 1'(t % 2));
    end

    bat_strobe(1023, 1);
    bat_strobe(1023, 0);
    bat_strobe(1, 0);
    bat_strobe(0, 1);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule